// File: doc/BRIEF.md
# Sleep-Aware Successive-Approximation Conversion Controller

This block sequences a successive-approximation conversion and decides what happens to it when the processor goes to sleep. Software writes one control byte. The byte holds a power-enable bit, a start/busy bit, a conversion-clock select, a channel number and a result-justification bit. The block then steps a trial code, most significant bit first, through an external comparator. It gets one decision per period of the selected conversion clock. When the conversion completes, it places the 10-bit code into a pair of result bytes and raises an interrupt flag.

Three of the four clock choices are derived from the system clock and stop when the core sleeps. The fourth is a self-timed clock that keeps running in sleep. With that clock, conversion waits one instruction cycle after the start, so a sleep request can land before the first decision. If sleep arrives, the outcome depends on the clock source. A running self-timed conversion finishes, and then either wakes the core (interrupt enabled) or powers the converter down (interrupt disabled). On any other clock, the conversion is aborted and the converter powers down. In every sleep power-down the enable bit still reads 1. Software leaves power-down by writing the control byte with the enable bit set.

Top module: `sleep_adc_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, `powered`, `irq_flag` and `wake_req` are 0, and the result bytes are not reset.
- R2: A control write with start = 1 and enable (bit 0) = 0 starts nothing: the busy bit (bit 1) stays 0 and no flag is raised.
- R3: A conversion makes one decision per conversion-clock period, MSB first. `trial_code` shows the bits decided so far with the bit under test set. A bit is kept when `cmp_in` is 1, so the final code equals the largest value the comparator accepts.
- R4: Clock select (bits 3:2) 00, 01 and 10 give 2, 8 and 32 system clocks per decision. From the write edge, the busy bit clears and `irq_flag` sets after 10 times that many cycles.
- R5: Clock select 11 (self-timed clock, 6 system clocks per decision) first waits 4 system clocks, giving 4 + 60 cycles from the write edge to completion.
- R6: Format bit (bit 7) = 1 puts the code right-justified in {res_hi, res_lo} (hi holds bits 9:8). Format bit = 0 left-justifies it (code times 64).
- R7: A self-timed conversion continues through a sleep request. If `irq_en` is 1, it then gives exactly one single-cycle `wake_req` pulse, updates the result, and stays powered.
- R8: A self-timed conversion that completes in sleep with `irq_en` = 0 stores its result and sets the flag. It gives no `wake_req`, drops `powered`, and leaves the enable bit reading 1.
- R9: A sleep request during a conversion on clock select 00/01/10 aborts it. Busy clears, `powered` drops, enable still reads 1, and neither the result nor the flag changes.
- R10: While busy, writes with enable = 1 change nothing: start = 0 does not abort, start = 1 does not restart, and the other fields keep their values. A write with enable = 0 aborts with no result or flag update.
- R11: Power-down ends on a control write with enable = 1, after which a new start converts normally.
- R12: `irq_flag` stays set until `flag_clr`. If completion and `flag_clr` coincide, the flag is set.
- R13: A sleep request while idle powers the converter down, with the enable bit still reading 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control-byte write strobe |
| ctl_wdata | input | 8 | {fmt, chan[2:0], clksel[1:0], start, enable} |
| ctl_rdata | output | 8 | Control byte read-back; bit 1 is busy |
| irq_en | input | 1 | Converter interrupt enable |
| flag_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Conversion-complete flag |
| sleep_req | input | 1 | Core enters sleep (one-cycle strobe) |
| ext_wake | input | 1 | Core woken by another source |
| wake_req | output | 1 | One-cycle wake request to the core |
| powered | output | 1 | Converter powered indication |
| cmp_in | input | 1 | Comparator: trial code not above input |
| trial_code | output | 10 | Trial code presented to the converter |
| res_hi | output | 8 | Result high byte |
| res_lo | output | 8 | Result low byte |

## Verification
A wrong bit decision or a wrong tick count shows at the ports at the first completion. The result bytes are off, or busy falls on the wrong cycle, so the sweep over every input code and every clock select catches it within one conversion. A wrong sleep decision shows within one cycle of the sleep strobe as a wrong `powered` or busy value. It shows at completion as a missing or extra `wake_req`, or as a result or flag that moved when it should not have.

// File: rtl/sleep_adc_pkg.sv
package sleep_adc_pkg;
  localparam int CTL_W = 8;
  localparam int CH_W  = 3;
  localparam int RES_W = 16;
  localparam logic [1:0] SEL_RC = 2'b11;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_DELAY = 2'd1, ST_CONV = 2'd2} conv_state_e;

  typedef struct packed {
    logic            fmt;
    logic [CH_W-1:0] chan;
    logic [1:0]      clksel;
    logic            start;
    logic            enable;
  } ctl_byte_t;

  // place an nb-bit code in a 16-bit result pair
  function automatic logic [RES_W-1:0] pack_result(input logic [RES_W-1:0] code,
                                                   input int nb, input logic right);
    if (right) return code;
    return code << (RES_W - nb);
  endfunction
endpackage

// File: rtl/sadc_tick_gen.sv
module sadc_tick_gen #(
  parameter int DIV_A  = 2,
  parameter int DIV_B  = 8,
  parameter int DIV_C  = 32,
  parameter int RC_DIV = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       gate,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int MAX_AB = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int MAX_CR = (DIV_C > RC_DIV) ? DIV_C : RC_DIV;
  localparam int MAXD   = (MAX_AB > MAX_CR) ? MAX_AB : MAX_CR;
  localparam int CW     = $clog2(MAXD + 1);

  logic [CW-1:0] cnt, lim;
  logic          active;

  always_comb begin
    case (sel)
      2'b00:   lim = CW'(DIV_A - 1);
      2'b01:   lim = CW'(DIV_B - 1);
      2'b10:   lim = CW'(DIV_C - 1);
      default: lim = CW'(RC_DIV - 1);
    endcase
  end

  // system-derived clocks stop in sleep; the self-timed one keeps going
  assign active = run && !(gate && (sel != sleep_adc_pkg::SEL_RC));
  assign tick   = active && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (active)    cnt <= tick ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/sadc_sar_core.sv
module sadc_sar_core #(
  parameter int NB = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          tick,
  input  logic          cmp,
  output logic [NB-1:0] trial,
  output logic [NB-1:0] code_now,
  output logic          last
);
  logic [NB-1:0] acc, mask;

  assign trial    = acc | mask;
  assign code_now = cmp ? trial : acc;
  assign last     = mask[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      mask <= '0;
    end else if (load) begin
      acc  <= '0;
      mask <= {1'b1, {(NB-1){1'b0}}};
    end else if (tick) begin
      acc  <= code_now;
      mask <= mask >> 1;
    end
  end
endmodule

// File: rtl/sadc_result_reg.sv
module sadc_result_reg #(
  parameter int NB = 10
) (
  input  logic          clk,
  input  logic          load,
  input  logic [NB-1:0] code,
  input  logic          right,
  output logic [7:0]    hi,
  output logic [7:0]    lo
);
  import sleep_adc_pkg::*;
  logic [RES_W-1:0] packed_q;

  // deliberately not reset: contents survive reset and are unknown at power-on
  always_ff @(posedge clk) begin
    if (load) packed_q <= pack_result(RES_W'(code), NB, right);
  end

  assign hi = packed_q[15:8];
  assign lo = packed_q[7:0];
endmodule

// File: rtl/sleep_adc_ctrl.sv
module sleep_adc_ctrl #(
  parameter int NBITS     = 10,
  parameter int DIV_A     = 2,
  parameter int DIV_B     = 8,
  parameter int DIV_C     = 32,
  parameter int RC_DIV    = 6,
  parameter int INSTR_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [7:0]       ctl_wdata,
  output logic [7:0]       ctl_rdata,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic             irq_flag,
  input  logic             sleep_req,
  input  logic             ext_wake,
  output logic             wake_req,
  output logic             powered,
  input  logic             cmp_in,
  output logic [NBITS-1:0] trial_code,
  output logic [7:0]       res_hi,
  output logic [7:0]       res_lo
);
  import sleep_adc_pkg::*;
  localparam int DW = $clog2(INSTR_CYC + 1);

  ctl_byte_t   wr_b;
  conv_state_e state;
  logic [DW-1:0] dcnt;
  logic        en_q, fmt_q, pd_q, asleep_q, irq_q, wake_q;
  logic [1:0]  sel_q;
  logic [CH_W-1:0] ch_q;

  // named internal events
  logic busy, rc_sel, start_evt, dis_abort, slp_abort, abort_evt;
  logic tick, conv_run, sar_last, conv_last, done_evt, wake_set, pd_set, pd_clr;
  logic [NBITS-1:0] code_now;

  assign wr_b      = ctl_byte_t'(ctl_wdata);
  assign busy      = (state != ST_IDLE);
  assign rc_sel    = (sel_q == SEL_RC);
  assign conv_run  = (state == ST_CONV);
  assign start_evt = ctl_wr && !busy && wr_b.enable && wr_b.start;
  assign dis_abort = ctl_wr && busy && !wr_b.enable;
  assign slp_abort = sleep_req && busy && !rc_sel;
  assign abort_evt = dis_abort || slp_abort;
  assign conv_last = conv_run && tick && sar_last;
  assign done_evt  = conv_last && !abort_evt;
  assign wake_set  = done_evt && asleep_q && irq_en;
  assign pd_set    = (sleep_req && (!busy || !rc_sel)) || (done_evt && asleep_q && !irq_en);
  assign pd_clr    = ctl_wr && !busy && wr_b.enable;

  sadc_tick_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .RC_DIV(RC_DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .run(conv_run), .gate(asleep_q), .sel(sel_q), .tick(tick)
  );

  sadc_sar_core #(.NB(NBITS)) sar_i (
    .clk(clk), .rst_n(rst_n), .load(start_evt), .tick(tick && conv_run), .cmp(cmp_in),
    .trial(trial_code), .code_now(code_now), .last(sar_last)
  );

  sadc_result_reg #(.NB(NBITS)) res_i (
    .clk(clk), .load(done_evt), .code(code_now), .right(fmt_q), .hi(res_hi), .lo(res_lo)
  );

  // control register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= 2'b00;
      ch_q  <= '0;
      fmt_q <= 1'b0;
    end else if (ctl_wr) begin
      if (!busy) begin
        en_q  <= wr_b.enable;
        sel_q <= wr_b.clksel;
        ch_q  <= wr_b.chan;
        fmt_q <= wr_b.fmt;
      end else if (!wr_b.enable) begin
        en_q <= 1'b0;
      end
    end
  end

  // conversion sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      dcnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          dcnt <= '0;
          if (start_evt) state <= (wr_b.clksel == SEL_RC) ? ST_DELAY : ST_CONV;
        end
        ST_DELAY: begin
          if (abort_evt) state <= ST_IDLE;
          else if (dcnt == DW'(INSTR_CYC - 1)) state <= ST_CONV;
          else dcnt <= dcnt + 1'b1;
        end
        ST_CONV: begin
          if (abort_evt || done_evt) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // sleep, power and interrupt bookkeeping
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd_q     <= 1'b0;
      asleep_q <= 1'b0;
      irq_q    <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      if (pd_set)      pd_q <= 1'b1;
      else if (pd_clr) pd_q <= 1'b0;

      if (sleep_req)                 asleep_q <= 1'b1;
      else if (ext_wake || wake_set) asleep_q <= 1'b0;

      if (done_evt)      irq_q <= 1'b1;
      else if (flag_clr) irq_q <= 1'b0;

      wake_q <= wake_set;
    end
  end

  assign ctl_rdata = {fmt_q, ch_q, sel_q, busy, en_q};
  assign irq_flag  = irq_q;
  assign wake_req  = wake_q;
  assign powered   = en_q && !pd_q;
endmodule

// File: rtl/sadc_checker.sv
module sadc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_rdata,
  input logic       irq_en,
  input logic       irq_flag,
  input logic       wake_req,
  input logic       powered,
  input logic [7:0] res_hi,
  input logic [7:0] res_lo,
  input logic       busy,
  input logic       asleep_q,
  input logic       done_evt,
  input logic       abort_evt,
  input logic       start_evt,
  input logic       rc_sel,
  input logic       conv_run
);
  // R7
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> ($past(done_evt) && $past(irq_en)));
  // R7
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);
  // R4
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (irq_flag && !ctl_rdata[1]));
  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!ctl_rdata[1] && $stable(res_hi) && $stable(res_lo)));
  // R2
  ignore_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_wdata[0] && !busy) |=> !ctl_rdata[1]);
  // R1
  off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[0] |-> !powered);
  // R8
  sleep_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && asleep_q && !irq_en) |=> (!powered && ctl_rdata[0] && !wake_req));
  // R5
  rc_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && ctl_wdata[3:2] == 2'b11) |=> (!conv_run && rc_sel));
endmodule

bind sleep_adc_ctrl sadc_checker chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
  .irq_en(irq_en), .irq_flag(irq_flag), .wake_req(wake_req), .powered(powered),
  .res_hi(res_hi), .res_lo(res_lo), .busy(busy), .asleep_q(asleep_q), .done_evt(done_evt),
  .abort_evt(abort_evt), .start_evt(start_evt), .rc_sel(rc_sel), .conv_run(conv_run)
);

// File: tb/sleep_adc_ctrl_tb_top.sv
module sleep_adc_ctrl_tb_top;
  localparam int NB = 10, INSTR = 4, RCD = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, irq_en = 0, flag_clr = 0, sleep_req = 0, ext_wake = 0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata, res_hi, res_lo;
  logic irq_flag, wake_req, powered, cmp_in;
  logic [NB-1:0] trial_code;
  logic [NB-1:0] vin = '0;
  int vectors = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  assign cmp_in = (trial_code <= vin);

  sleep_adc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .irq_en(irq_en), .flag_clr(flag_clr), .irq_flag(irq_flag), .sleep_req(sleep_req),
    .ext_wake(ext_wake), .wake_req(wake_req), .powered(powered), .cmp_in(cmp_in),
    .trial_code(trial_code), .res_hi(res_hi), .res_lo(res_lo)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] s);
    case (s)
      2'b00: return 2;
      2'b01: return 8;
      2'b10: return 32;
      default: return RCD;
    endcase
  endfunction

  function automatic int lat_of(input logic [1:0] s);
    return (s == 2'b11) ? INSTR + NB * RCD : NB * div_of(s);
  endfunction

  function automatic int expect_res(input int v, input bit right);
    return right ? v : v * 64;
  endfunction

  task automatic wr(input logic [7:0] d);
    ctl_wr = 1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic pulse_sleep();
    sleep_req = 1; @(negedge clk); sleep_req = 0;
  endtask

  task automatic pulse_wake();
    ext_wake = 1; @(negedge clk); ext_wake = 0;
  endtask

  task automatic clear_flag();
    flag_clr = 1; @(negedge clk); flag_clr = 0;
  endtask

  function automatic logic [7:0] cbyte(input bit f, input int ch, input logic [1:0] s,
                                       input bit go, input bit en);
    return {f, 3'(ch), s, go, en};
  endfunction

  // one full conversion from idle, with latency, result, flag and field checks
  task automatic run_conv(input logic [1:0] s, input bit right, input int v, input string tag);
    int lat;
    vin = NB'(v);
    wr(cbyte(right, v, s, 1'b1, 1'b1));
    lat = 0;
    check(ctl_rdata[1] == 1'b1, {tag, " busy after start"}, ctl_rdata[1], 1);
    while (ctl_rdata[1] && lat < 5000) begin @(negedge clk); lat++; end
    check(lat == lat_of(s), {tag, " R4/R5 latency"}, lat, lat_of(s));
    check({res_hi, res_lo} == 16'(expect_res(v, right)), {tag, " R3/R6 result"},
          {res_hi, res_lo}, expect_res(v, right));
    check(irq_flag == 1'b1, {tag, " R4 flag"}, irq_flag, 1);
    check(ctl_rdata == cbyte(right, v, s, 1'b0, 1'b1), {tag, " R10 fields"}, ctl_rdata,
          cbyte(right, v, s, 1'b0, 1'b1));
    clear_flag();
    check(irq_flag == 1'b0, {tag, " R12 flag cleared"}, irq_flag, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int lat, wakes;
    logic [15:0] prev;
    repeat (3) @(negedge clk);
    // R1
    check(ctl_rdata == 8'h00, "R1 ctl reset", ctl_rdata, 0);
    check(powered == 1'b0 && irq_flag == 1'b0 && wake_req == 1'b0, "R1 outputs reset",
          {powered, irq_flag, wake_req}, 0);
    rst_n = 1;
    @(negedge clk);
    check(ctl_rdata == 8'h00 && !powered, "R1 after release", ctl_rdata, 0);

    // R2: start with enable low
    wr(cbyte(1'b1, 0, 2'b00, 1'b1, 1'b0));
    repeat (40) @(negedge clk);
    check(ctl_rdata[1] == 1'b0, "R2 no busy", ctl_rdata[1], 0);
    check(irq_flag == 1'b0, "R2 no flag", irq_flag, 0);

    // R3 R4 R6: every code on the fastest clock, strided on the others
    for (int v = 0; v < 1024; v++) run_conv(2'b00, v[0], v, "sweep00");
    for (int v = 0; v < 1024; v += 16) run_conv(2'b01, v[4], v, "sweep01");
    for (int v = 1; v < 1024; v += 67) run_conv(2'b10, v[1], v, "sweep10");
    // R5
    for (int v = 3; v < 1024; v += 4) run_conv(2'b11, v[2], v, "sweep11");

    // R12: completion with flag_clr held -> set wins
    vin = 10'd500;
    flag_clr = 1;
    wr(cbyte(1'b1, 0, 2'b00, 1'b1, 1'b1));
    while (ctl_rdata[1]) @(negedge clk);
    check(irq_flag == 1'b1, "R12 set wins", irq_flag, 1);
    @(negedge clk);
    check(irq_flag == 1'b0, "R12 cleared later", irq_flag, 0);
    flag_clr = 0;

    // R7: self-timed conversion through sleep with interrupt enabled
    irq_en = 1; vin = 10'd613;
    wr(cbyte(1'b1, 1, 2'b11, 1'b1, 1'b1));
    pulse_sleep();
    check(ctl_rdata[1] == 1'b1 && powered, "R7 continues in sleep", ctl_rdata[1], 1);
    wakes = 0;
    for (int i = 0; i < 120; i++) begin @(negedge clk); if (wake_req) wakes++; end
    check(wakes == 1, "R7 one wake pulse", wakes, 1);
    check(powered == 1'b1, "R7 stays powered", powered, 1);
    check({res_hi, res_lo} == 16'd613, "R7 result", {res_hi, res_lo}, 613);
    clear_flag();

    // R8: self-timed through sleep, interrupt disabled
    irq_en = 0; vin = 10'd77;
    wr(cbyte(1'b0, 2, 2'b11, 1'b1, 1'b1));
    pulse_sleep();
    wakes = 0;
    for (int i = 0; i < 120; i++) begin @(negedge clk); if (wake_req) wakes++; end
    check(wakes == 0, "R8 no wake", wakes, 0);
    check(powered == 1'b0, "R8 powered down", powered, 0);
    check(ctl_rdata[0] == 1'b1, "R8 enable reads 1", ctl_rdata[0], 1);
    check({res_hi, res_lo} == 16'(77 * 64), "R8 result", {res_hi, res_lo}, 77 * 64);
    check(irq_flag == 1'b1, "R8 flag", irq_flag, 1);
    clear_flag();
    pulse_wake();
    // R11: rewrite enable
    wr(cbyte(1'b0, 2, 2'b11, 1'b0, 1'b1));
    check(powered == 1'b1, "R11 enable rewrite powers up", powered, 1);

    // R9: sleep aborts a system-clock conversion
    prev = {res_hi, res_lo};
    vin = 10'd300;
    wr(cbyte(1'b1, 3, 2'b01, 1'b1, 1'b1));
    repeat (10) @(negedge clk);
    pulse_sleep();
    check(ctl_rdata[1] == 1'b0, "R9 busy cleared", ctl_rdata[1], 0);
    check(powered == 1'b0, "R9 powered down", powered, 0);
    check(ctl_rdata[0] == 1'b1, "R9 enable reads 1", ctl_rdata[0], 1);
    repeat (150) @(negedge clk);
    check(irq_flag == 1'b0, "R9 no flag", irq_flag, 0);
    check({res_hi, res_lo} == prev, "R9 result kept", {res_hi, res_lo}, prev);
    pulse_wake();
    // R11: a new start converts normally
    run_conv(2'b01, 1'b1, 300, "R11 restart");

    // R10: writes during busy
    vin = 10'd777;
    wr(cbyte(1'b1, 5, 2'b01, 1'b1, 1'b1));
    lat = 0;
    repeat (10) begin @(negedge clk); lat++; end
    wr(cbyte(1'b0, 2, 2'b00, 1'b0, 1'b1)); lat++;
    check(ctl_rdata == cbyte(1'b1, 5, 2'b01, 1'b1, 1'b1), "R10 fields held", ctl_rdata,
          cbyte(1'b1, 5, 2'b01, 1'b1, 1'b1));
    repeat (10) begin @(negedge clk); lat++; end
    wr(cbyte(1'b1, 5, 2'b01, 1'b1, 1'b1)); lat++;
    while (ctl_rdata[1] && lat < 5000) begin @(negedge clk); lat++; end
    check(lat == 80, "R10 no abort no restart", lat, 80);
    check({res_hi, res_lo} == 16'd777, "R10 result", {res_hi, res_lo}, 777);
    clear_flag();
    // R10: enable low aborts
    prev = {res_hi, res_lo};
    vin = 10'd5;
    wr(cbyte(1'b1, 0, 2'b01, 1'b1, 1'b1));
    repeat (10) @(negedge clk);
    wr(cbyte(1'b1, 0, 2'b01, 1'b0, 1'b0));
    check(ctl_rdata[1:0] == 2'b00 && !powered, "R10 disable aborts", ctl_rdata[1:0], 0);
    repeat (100) @(negedge clk);
    check(irq_flag == 1'b0 && {res_hi, res_lo} == prev, "R10 abort quiet",
          {res_hi, res_lo}, prev);

    // R13: idle sleep
    wr(cbyte(1'b0, 0, 2'b11, 1'b0, 1'b1));
    check(powered == 1'b1, "R13 powered before", powered, 1);
    pulse_sleep();
    check(powered == 1'b0 && ctl_rdata[0], "R13 idle sleep powers down", powered, 0);
    pulse_wake();

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule